// File: doc/BRIEF.md
# Register-Driven SPI Command Engine

This block is an SPI master that a host drives through eight byte registers. The host first loads a command byte, up to three address bytes and one data byte. It then writes a control byte, and that write starts the transfer. The control byte carries three fields: the number of bytes to shift out, the number of bytes to read back afterwards, and a choice between a fast and a slow serial clock. The engine then selects the device, shifts out the command bytes MSB first in SPI mode 0, and shifts in the requested reply bytes. It stores the reply bytes in read registers and releases the device. A busy bit in the status byte stays set from the start of the transfer until one system clock after the device is released.

Only four outbound lengths can be encoded: 1, 2, 4 or 5 bytes. The three address bytes are stored in the register bank in the reverse of the order in which they go out on the wire. The data byte register is shared with the third reply byte. While a transfer runs, every host write is discarded, so the bytes being sent cannot change under the sequencer.

The sequencer has four states. IDLE is left for SETUP by a valid control write. SETUP asserts chip select with the first bit already on MOSI, and passes to SHIFT after one half clock period. SHIFT toggles the serial clock and passes to DONE on the falling edge that ends the last byte. DONE releases chip select with busy still set, and returns to IDLE after one system clock.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, busy is 0, spi_cs_n is 1, spi_sck is 0 and every register at offsets 1 to 7 reads 0x00.
- R2: A host write to offset 0 while idle starts a transfer only when data bits 7:5 are 3'b010, i.e. values 0x4_ or 0x5_ in the upper nibble. Any other value leaves the engine idle with chip select high.
- R3: Control bits 1:0 set the outbound length: 0 sends 1 byte, 1 sends 2 bytes, 2 sends 4 bytes and 3 sends 5 bytes.
- R4: The outbound order is fixed. Offset 1 always goes first. For lengths 4 and 5 it is followed by offsets 4, 3 and 2 in that order. For lengths 2 and 5, offset 7 is sent last.
- R5: Control bits 3:2 give a reply count of 0 to 3 bytes, shifted in after the outbound bytes with MOSI held at 0. Reply bytes are stored at offsets 5, 6 and 7 in arrival order.
- R6: Bits are MSB first in SPI mode 0. SCK idles low, MOSI changes only while SCK is low, and MISO is sampled on the rising edge of SCK.
- R7: Control bit 4 = 1 selects the fast clock, with SCK high and low for HALF_FAST system clocks each. Bit 4 = 0 selects the slow clock, with HALF_SLOW system clocks each.
- R8: Reading offset 0 returns busy in bit 7 and 0 in bits 6:0. Busy is 1 for the whole time spi_cs_n is low, and it clears exactly one system clock after spi_cs_n returns high.
- R9: Host writes made while busy, including writes to offset 0, are ignored: they neither start a new transfer nor change any register.
- R10: A transfer produces exactly 8 × (outbound bytes + reply bytes) rising SCK edges, and chip select goes low once per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 3 | Register offset of the host write |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 3 | Register offset being read |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| busy | output | 1 | Transfer in progress |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The hardest case to reach is a transfer in which the data register is used on both sides: it is sent as the final outbound byte and is then overwritten by the third reply byte. Another hard case is a host write that arrives in the middle of a shift. The bench sweeps every combination of outbound length, reply count and clock speed, loading fresh register contents each time. A bench-side device model returns a known byte stream, so the expected reply bytes and the captured MOSI stream can be computed from byte position alone. One extra long slow transfer is interrupted by a control write and a command-byte write. A register readback and a count of chip-select events then show that both writes were dropped.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_DONE
    } seq_state_t;

    localparam logic [2:0] START_PREFIX = 3'b010;

    typedef struct packed {
        logic [7:0] opcode;    // offset 1
        logic [7:0] addr_lo;   // offset 2, sent last of the address bytes
        logic [7:0] addr_mid;  // offset 3
        logic [7:0] addr_hi;   // offset 4, sent first of the address bytes
        logic [7:0] data;      // offset 7
    } tx_regs_t;

    function automatic logic [2:0] wire_len(input logic [1:0] code);
        logic [2:0] n;
        unique case (code)
            2'd0: n = 3'd1;
            2'd1: n = 3'd2;
            2'd2: n = 3'd4;
            default: n = 3'd5;
        endcase
        return n;
    endfunction

    function automatic logic [7:0] tx_pick(input logic [1:0] code,
                                           input logic [2:0] idx,
                                           input tx_regs_t r);
        logic [7:0] b;
        b = 8'h00;
        if (idx == 3'd0) begin
            b = r.opcode;
        end else if (code == 2'd1) begin
            b = r.data;
        end else if (code[1]) begin
            unique case (idx)
                3'd1: b = r.addr_hi;
                3'd2: b = r.addr_mid;
                3'd3: b = r.addr_lo;
                default: b = r.data;
            endcase
        end
        return b;
    endfunction

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int NUM_OFFSETS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_we,
    input  logic [2:0] host_addr,
    input  logic [7:0] host_wdata,
    input  logic       rx_we,
    input  logic [1:0] rx_slot,
    input  logic [7:0] rx_data,
    input  logic [2:0] rd_addr,
    input  logic       busy,
    output logic [7:0] rd_data,
    output tx_regs_t   tx_regs
);

    localparam int RX_BASE = 5;

    logic [7:0] regv [NUM_OFFSETS];

    assign regv[0] = 8'h00;

    for (genvar g = 1; g < NUM_OFFSETS; g++) begin : g_reg
        localparam bit HOST_W = (g <= 4) || (g == 7);
        localparam bit RX_W   = (g >= RX_BASE);
        logic rx_hit;
        logic host_hit;

        assign rx_hit   = RX_W && rx_we && (({1'b0, rx_slot} + 3'(RX_BASE)) == 3'(g));
        assign host_hit = HOST_W && host_we && (host_addr == 3'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regv[g] <= 8'h00;
            end else if (rx_hit) begin
                regv[g] <= rx_data;
            end else if (host_hit) begin
                regv[g] <= host_wdata;
            end
        end
    end

    always_comb begin
        if (rd_addr == 3'd0) begin
            rd_data = {busy, 7'b0};
        end else begin
            rd_data = regv[rd_addr];
        end
    end

    assign tx_regs.opcode   = regv[1];
    assign tx_regs.addr_lo  = regv[2];
    assign tx_regs.addr_mid = regv[3];
    assign tx_regs.addr_hi  = regv[4];
    assign tx_regs.data     = regv[7];

endmodule

// File: rtl/spi_cmd_clkdiv.sv
module spi_cmd_clkdiv #(
    parameter int HALF_FAST = 1,
    parameter int HALF_SLOW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fast,
    output logic tick
);

    localparam int HALF_MAX = (HALF_FAST > HALF_SLOW) ? HALF_FAST : HALF_SLOW;
    localparam int CW       = $clog2(HALF_MAX) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    assign limit = fast ? CW'(HALF_FAST - 1) : CW'(HALF_SLOW - 1);
    assign tick  = en && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [4:0] ctrl,
    input  tx_regs_t   tx_regs,
    input  logic       tick,
    input  logic       miso,
    output logic       busy,
    output logic       clk_en,
    output logic       fast,
    output logic       sck,
    output logic       cs_n,
    output logic       mosi,
    output logic       rx_we,
    output logic [1:0] rx_slot,
    output logic [7:0] rx_data
);

    seq_state_t state, state_nx;

    logic       fast_q;
    logic [1:0] wcode_q;
    logic [1:0] rcnt_q;
    logic [3:0] byte_idx;
    logic [2:0] bit_idx;
    logic [7:0] shreg;
    logic [7:0] rxsh;
    logic       sck_q;

    logic [2:0] wlen;
    logic [3:0] total;
    logic       rise_edge;
    logic       fall_edge;
    logic       byte_end;
    logic       last_byte;
    logic       in_read;
    logic [3:0] next_idx;
    logic [7:0] next_byte;

    assign wlen      = wire_len(wcode_q);
    assign total     = {1'b0, wlen} + {2'b0, rcnt_q};
    assign rise_edge = (state == ST_SHIFT) && tick && !sck_q;
    assign fall_edge = (state == ST_SHIFT) && tick && sck_q;
    assign byte_end  = fall_edge && (bit_idx == 3'd7);
    assign last_byte = (byte_idx == total - 4'd1);
    assign in_read   = (byte_idx >= {1'b0, wlen});
    assign next_idx  = byte_idx + 4'd1;
    assign next_byte = (next_idx < {1'b0, wlen}) ? tx_pick(wcode_q, next_idx[2:0], tx_regs) : 8'h00;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_SETUP;
            ST_SETUP: if (tick) state_nx = ST_SHIFT;
            ST_SHIFT: if (byte_end && last_byte) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fast_q   <= 1'b0;
            wcode_q  <= 2'd0;
            rcnt_q   <= 2'd0;
            byte_idx <= 4'd0;
            bit_idx  <= 3'd0;
            shreg    <= 8'h00;
            rxsh     <= 8'h00;
            sck_q    <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                fast_q   <= ctrl[4];
                rcnt_q   <= ctrl[3:2];
                wcode_q  <= ctrl[1:0];
                byte_idx <= 4'd0;
                bit_idx  <= 3'd0;
                shreg    <= tx_regs.opcode;
                sck_q    <= 1'b0;
            end
            if (rise_edge) begin
                sck_q <= 1'b1;
                rxsh  <= {rxsh[6:0], miso};
            end
            if (fall_edge) begin
                sck_q <= 1'b0;
                if (bit_idx == 3'd7) begin
                    bit_idx <= 3'd0;
                    if (!last_byte) begin
                        byte_idx <= next_idx;
                        shreg    <= next_byte;
                    end
                end else begin
                    bit_idx <= bit_idx + 3'd1;
                    shreg   <= {shreg[6:0], 1'b0};
                end
            end
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        cs_n    = !((state == ST_SETUP) || (state == ST_SHIFT));
        clk_en  = (state == ST_SETUP) || (state == ST_SHIFT);
        fast    = fast_q;
        sck     = sck_q;
        mosi    = shreg[7];
        rx_we   = byte_end && in_read;
        rx_slot = 2'(byte_idx - {1'b0, wlen});
        rx_data = rxsh;
    end

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int HALF_FAST = 1,
    parameter int HALF_SLOW = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       busy,
    output logic       spi_sck,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);

    logic       host_ok;
    logic       start;
    logic       rx_we;
    logic [1:0] rx_slot;
    logic [7:0] rx_data;
    logic       clk_en;
    logic       fast;
    logic       tick;
    tx_regs_t   tx_regs;

    assign host_ok = wr_en && !busy;
    assign start   = host_ok && (wr_addr == 3'd0) && (wr_data[7:5] == START_PREFIX);

    spi_cmd_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_ok),
        .host_addr  (wr_addr),
        .host_wdata (wr_data),
        .rx_we      (rx_we),
        .rx_slot    (rx_slot),
        .rx_data    (rx_data),
        .rd_addr    (rd_addr),
        .busy       (busy),
        .rd_data    (rd_data),
        .tx_regs    (tx_regs)
    );

    spi_cmd_clkdiv #(
        .HALF_FAST (HALF_FAST),
        .HALF_SLOW (HALF_SLOW)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (clk_en),
        .fast  (fast),
        .tick  (tick)
    );

    spi_cmd_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .ctrl    (wr_data[4:0]),
        .tx_regs (tx_regs),
        .tick    (tick),
        .miso    (spi_miso),
        .busy    (busy),
        .clk_en  (clk_en),
        .fast    (fast),
        .sck     (spi_sck),
        .cs_n    (spi_cs_n),
        .mosi    (spi_mosi),
        .rx_we   (rx_we),
        .rx_slot (rx_slot),
        .rx_data (rx_data)
    );

endmodule

// File: rtl/spi_cmd_checker.sv
module spi_cmd_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic spi_cs_n,
    input logic spi_sck,
    input logic spi_mosi
);

    AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);                                        // R6

    AST_MOSI_STEADY_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));            // R6

    AST_BUSY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);                                           // R8

    AST_BUSY_HOLD_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> busy);                                     // R8

    AST_BUSY_DROP_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |=> !busy);                                    // R8

    AST_NO_RESELECT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |=> spi_cs_n);                                 // R10

endmodule

bind spi_cmd_engine spi_cmd_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .spi_cs_n (spi_cs_n),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi)
);

// File: tb/sim_spi_cmd_engine.sv
`timescale 1ns/1ps
module sim_spi_cmd_engine;

    localparam int HALF_FAST = 1;
    localparam int HALF_SLOW = 2;
    localparam int TCLK      = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       busy;
    logic       spi_sck;
    logic       spi_cs_n;
    logic       spi_mosi;
    logic       spi_miso = 1'b0;

    int errors = 0;
    int checks = 0;

    always #(TCLK/2) clk = ~clk;

    spi_cmd_engine #(.HALF_FAST(HALF_FAST), .HALF_SLOW(HALF_SLOW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- device model ----------------
    logic [7:0] slv_seed = 8'h00;
    logic [7:0] cap [8];
    int  slv_bits  = 0;
    int  cs_falls  = 0;
    time t_rise0   = 0;
    time t_rise1   = 0;

    function automatic logic [7:0] resp_byte(input int k, input logic [7:0] s);
        return 8'((8'hC3 ^ 8'(k * 29)) ^ s);
    endfunction

    always @(negedge spi_cs_n) begin
        slv_bits = 0;
        cs_falls = cs_falls + 1;
        for (int i = 0; i < 8; i++) cap[i] = 8'h00;
        spi_miso = resp_byte(0, slv_seed)[7];
    end

    always @(posedge spi_sck) begin
        if (slv_bits < 64) cap[slv_bits / 8][7 - (slv_bits % 8)] = spi_mosi;
        if (slv_bits == 0) t_rise0 = $time;
        if (slv_bits == 1) t_rise1 = $time;
        slv_bits = slv_bits + 1;
    end

    always @(negedge spi_sck) begin
        if (slv_bits < 64) spi_miso = resp_byte(slv_bits / 8, slv_seed)[7 - (slv_bits % 8)];
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
        rd_addr = 3'd0;
    endtask

    function automatic int wlen_of(input int code);
        return (code == 0) ? 1 : (code == 1) ? 2 : (code == 2) ? 4 : 5;
    endfunction

    // wait with timeout for chip select release; returns 0 on timeout
    task automatic wait_release(output bit ok);
        int n;
        n = 0;
        while (spi_cs_n == 1'b0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        ok = (n < 5000);
    endtask

    // one full transfer with checks
    task automatic run_xfer(input int wc, input int rc, input int fast, input int seed);
        logic [7:0] op, a2, a3, a4, dt, v;
        logic [7:0] expq [8];
        int wl, tot, half, falls0;
        bit ok;
        string tag;
        op = 8'(seed * 7 + 8'h11);
        a2 = 8'(seed * 13 + 8'h22);
        a3 = 8'(seed * 17 + 8'h35);
        a4 = 8'(seed * 19 + 8'h4C);
        dt = 8'(seed * 23 + 8'h5B);
        slv_seed = 8'(seed);
        wl  = wlen_of(wc);
        tot = wl + rc;
        half = fast ? HALF_FAST : HALF_SLOW;
        for (int i = 0; i < 8; i++) expq[i] = 8'h00;
        expq[0] = op;
        if (wc == 1) expq[1] = dt;
        if (wc >= 2) begin expq[1] = a4; expq[2] = a3; expq[3] = a2; end
        if (wc == 3) expq[4] = dt;
        host_wr(3'd1, op);
        host_wr(3'd2, a2);
        host_wr(3'd3, a3);
        host_wr(3'd4, a4);
        host_wr(3'd7, dt);
        falls0 = cs_falls;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0;
        wr_data = {3'b010, 1'(fast), 2'(rc), 2'(wc)};
        @(negedge clk);
        wr_en = 1'b0;
        tag = $sformatf("wc=%0d rc=%0d fast=%0d", wc, rc, fast);
        host_rd(3'd0, v);
        chk(v == 8'h80 && spi_cs_n == 1'b0, "R2", {"start/busy ", tag}, v, 8'h80);
        chk(v == 8'h80, "R8", {"status during xfer ", tag}, v, 8'h80);
        wait_release(ok);
        chk(ok, "R10", {"watchdog release ", tag}, int'(ok), 1);
        host_rd(3'd0, v);
        chk(v[7] == 1'b1, "R8", {"busy one clock after release ", tag}, v, 8'h80);
        @(negedge clk);
        host_rd(3'd0, v);
        chk(v == 8'h00, "R8", {"busy cleared ", tag}, v, 8'h00);
        chk(slv_bits == 8 * tot, "R10", {"sck rising count ", tag}, slv_bits, 8 * tot);
        chk(cs_falls == falls0 + 1, "R10", {"one select ", tag}, cs_falls - falls0, 1);
        for (int i = 0; i < wl; i++)
            chk(cap[i] == expq[i], (i == 0) ? "R4" : "R3",
                $sformatf("mosi byte %0d %s", i, tag), cap[i], expq[i]);
        for (int i = wl; i < tot; i++)
            chk(cap[i] == 8'h00, "R5", $sformatf("mosi low in read byte %0d %s", i, tag), cap[i], 0);
        for (int j = 0; j < rc; j++) begin
            host_rd(3'(5 + j), v);
            chk(v == resp_byte(wl + j, slv_seed), "R5",
                $sformatf("reply slot %0d %s", j, tag), v, resp_byte(wl + j, slv_seed));
        end
        if (rc < 3) begin
            host_rd(3'd7, v);
            chk(v == dt, "R5", {"offset 7 keeps data ", tag}, v, dt);
        end
        if (tot > 0)
            chk(int'(t_rise1 - t_rise0) == 2 * half * TCLK, "R7",
                {"sck period ", tag}, int'(t_rise1 - t_rise0), 2 * half * TCLK);
        chk(spi_sck == 1'b0, "R6", {"sck idle low ", tag}, spi_sck, 0);
    endtask

    // ---------------- main ----------------
    bit done = 1'b0;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL R10 watchdog expired: actual=0x0 expected=0x1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        int falls0, bits0;
        bit ok;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy at reset", busy, 0);
        chk(spi_cs_n == 1'b1, "R1", "cs_n at reset", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R1", "sck at reset", spi_sck, 0);
        for (int a = 1; a < 8; a++) begin
            host_rd(3'(a), v);
            chk(v == 8'h00, "R1", $sformatf("offset %0d at reset", a), v, 0);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R4 R5 R7 sweep over all lengths, reply counts and speeds
        for (int f = 0; f < 2; f++)
            for (int wc = 0; wc < 4; wc++)
                for (int rc = 0; rc < 4; rc++)
                    run_xfer(wc, rc, f, f * 16 + wc * 4 + rc + 1);

        // R2 invalid start codes leave the engine idle
        falls0 = cs_falls;
        host_wr(3'd0, 8'h63);
        host_wr(3'd0, 8'h8F);
        host_wr(3'd0, 8'h1F);
        repeat (10) @(negedge clk);
        chk(cs_falls == falls0, "R2", "no select on bad code", cs_falls - falls0, 0);
        host_rd(3'd0, v);
        chk(v == 8'h00, "R2", "idle after bad code", v, 0);

        // R9 writes while busy are ignored
        host_wr(3'd1, 8'h9A);
        falls0 = cs_falls;
        host_wr(3'd0, 8'h4F);          // slow, 5 out, 3 in
        repeat (6) @(negedge clk);
        host_wr(3'd0, 8'h50);          // would restart as 1-byte
        host_wr(3'd1, 8'hEE);          // would change opcode
        bits0 = 0;
        wait_release(ok);
        chk(ok, "R9", "release after busy writes", int'(ok), 1);
        chk(slv_bits == 64, "R9", "transfer length unchanged", slv_bits, 64);
        repeat (20) @(negedge clk);
        chk(cs_falls == falls0 + 1, "R9", "no restart from busy write", cs_falls - falls0, 1);
        host_rd(3'd1, v);
        chk(v == 8'h9A, "R9", "opcode untouched by busy write", v, 8'h9A);
        chk(cap[0] == 8'h9A, "R9", "opcode sent unchanged", cap[0], 8'h9A);
        bits0 = bits0 + 1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule